// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block lets an 8-bit processor with a 64 KB address space reach a larger physical store through a 32 KB window. The window is the lower half of the processor's memory map. It can be aimed at any 32 KB page of a 1 MB read-only store or of a 512 KB read/write store. Two page registers hold the mapping, and the processor loads them with I/O writes. For each window access the block produces a 20-bit physical address and one of two chip selects. It also produces a write strobe, which it withholds whenever the target is read-only.

The device choice lives in the read-only page register. While bit 7 of that register is clear, the window shows a read-only page. While it is set, the window shows the page held in the read/write page register. Each page register answers at four consecutive I/O ports. Only the low five bits of the port address are decoded. The registers cannot be read back: an I/O read of a register port returns a fixed undriven-bus value and has no side effect.

Top module: `bank_window_map`

## Requirements
- R1: While reset is asserted, and afterwards until a register write, both page registers are zero. A window read at address A therefore asserts rom_cs and gives phys_addr = A.
- R2: phys_addr[14:0] always equals mem_addr[14:0].
- R3: With bit 7 of the read-only page register clear, phys_addr[19:15] equals bits 4:0 of that register. Its bits 6:5 have no effect.
- R4: With bit 7 of the read-only page register set, phys_addr[18:15] equals bits 3:0 of the read/write page register and phys_addr[19] is 0. Bits 7:4 of the read/write page register have no effect.
- R5: Only bit 7 of the read-only page register selects the device: 0 gives rom_cs, 1 gives ram_cs. Bit 7 of the read/write page register does not change the selection. rom_cs and ram_cs are never high together.
- R6: A window write while the read-only device is selected asserts rom_cs with mem_we low. A window write while the read/write device is selected asserts ram_cs and mem_we.
- R7: When mem_addr[15] is 1, or when neither mem_rd nor mem_wr is high, rom_cs, ram_cs and mem_we are all low.
- R8: An I/O write whose low five address bits are 0x18–0x1B loads the read/write page register. Low bits 0x1C–0x1F load the read-only page register. io_addr[7:5] is ignored, and a write to any other port leaves the mapping unchanged.
- R9: An I/O read whose low five bits are 0x18–0x1F drives io_hit high and io_rdata to 0xFF, and leaves the mapping unchanged. Reads of any other port give io_hit low and io_rdata 0x00.
- R10: A register write takes effect at the clock edge that samples io_wr. A window access during the cycle of the write still uses the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_addr | input | 16 | Processor memory address |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| io_addr | input | 8 | Processor I/O port address |
| io_wr | input | 1 | I/O write strobe, active high |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for the page-register ports |
| io_hit | output | 1 | I/O read addressed a page-register port |
| phys_addr | output | 20 | Physical address for the selected store |
| rom_cs | output | 1 | Read-only store select |
| ram_cs | output | 1 | Read/write store select |
| mem_we | output | 1 | Write strobe to the read/write store |

## Verification
The hardest case to reach from the ports is a memory access in the same cycle as a page register update. The stimulus holds a window read while io_wr is high, samples before the clock edge to see the old page, and samples again after the edge to see the new one. Every register value is swept and written through rotating aliased ports with random upper address bits. Unused register bits and the cross-register select bit are set to non-zero values, so that a decode using the wrong bit shows up as a wrong address or a wrong chip select.

// File: rtl/bwm_pkg.sv
`timescale 1ns/1ps
package bwm_pkg;

   // Which page register an I/O port address lands on.
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_RAM  = 2'd1,
      TGT_ROM  = 2'd2
   } latch_tgt_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bwm_io_decode.sv
`timescale 1ns/1ps
module bwm_io_decode
   import bwm_pkg::*;
#(
   parameter int IO_AW     = 8,
   parameter int DEC_W     = 5,
   parameter int ALIAS_W   = 2,
   parameter int RAM_PORT  = 24,
   parameter int ROM_PORT  = 28
) (
   input  logic [IO_AW-1:0] io_addr,
   output latch_tgt_e       tgt
);
   localparam logic [DEC_W-1:0] RAM_B = DEC_W'(RAM_PORT);
   localparam logic [DEC_W-1:0] ROM_B = DEC_W'(ROM_PORT);

   generate
      if (DEC_W > IO_AW || DEC_W < 1)
         $error("bwm_io_decode: DEC_W must lie in 1..IO_AW");
      if (ALIAS_W >= DEC_W || ALIAS_W < 0)
         $error("bwm_io_decode: ALIAS_W must be below DEC_W");
      if ((RAM_PORT >> ALIAS_W) == (ROM_PORT >> ALIAS_W))
         $error("bwm_io_decode: port groups overlap");
   endgenerate

   logic [DEC_W-1:0] low;
   logic [IO_AW-1:0] unused_io_addr;
   assign low            = io_addr[DEC_W-1:0];
   assign unused_io_addr = io_addr;

   always_comb begin
      tgt = TGT_NONE;
      if (low[DEC_W-1:ALIAS_W] == RAM_B[DEC_W-1:ALIAS_W])
         tgt = TGT_RAM;
      else if (low[DEC_W-1:ALIAS_W] == ROM_B[DEC_W-1:ALIAS_W])
         tgt = TGT_ROM;
   end
endmodule

// File: rtl/bwm_page_latch.sv
`timescale 1ns/1ps
module bwm_page_latch #(
   parameter int DW      = 8,
   parameter int KEEP_W  = 4,
   parameter bit HAS_SEL = 1'b0,
   parameter int SEL_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DW-1:0]     wdata,
   output logic [KEEP_W-1:0] page,
   output logic              sel
);
   generate
      if (KEEP_W < 1 || KEEP_W > DW)
         $error("bwm_page_latch: KEEP_W must lie in 1..DW");
      if (HAS_SEL && (SEL_BIT < KEEP_W || SEL_BIT >= DW))
         $error("bwm_page_latch: SEL_BIT must sit above the page field");
   endgenerate

   logic [DW-1:0] unused_wdata;
   assign unused_wdata = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         page <= '0;
      else if (load)
         page <= wdata[KEEP_W-1:0];
   end

   generate
      if (HAS_SEL) begin : g_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sel <= 1'b0;
            else if (load)
               sel <= wdata[SEL_BIT];
         end
      end else begin : g_nosel
         assign sel = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/bwm_translate.sv
`timescale 1ns/1ps
module bwm_translate #(
   parameter int CPU_AW = 16,
   parameter int OFS_W  = 15,
   parameter int ROM_W  = 5,
   parameter int RAM_W  = 4,
   parameter int PA_W   = 20
) (
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [ROM_W-1:0]  rom_page,
   input  logic [RAM_W-1:0]  ram_page,
   input  logic              ram_mode,
   output logic [PA_W-1:0]   phys,
   output logic              rom_cs,
   output logic              ram_cs,
   output logic              we
);
   localparam int BANK_W = PA_W - OFS_W;

   generate
      if (OFS_W >= CPU_AW)
         $error("bwm_translate: window must be smaller than the address space");
      if (BANK_W < ROM_W || BANK_W < RAM_W)
         $error("bwm_translate: PA_W too narrow for the page fields");
   endgenerate

   logic in_window;
   generate
      if (OFS_W == CPU_AW - 1) begin : g_half
         assign in_window = ~cpu_addr[CPU_AW-1];
      end else begin : g_part
         assign in_window = (cpu_addr[CPU_AW-1:OFS_W] == '0);
      end
   endgenerate

   logic [BANK_W-1:0] bank;
   always_comb begin
      if (ram_mode)
         bank = BANK_W'(ram_page);
      else
         bank = BANK_W'(rom_page);
   end

   logic access;
   assign access = in_window & (rd | wr);
   assign phys   = {bank, cpu_addr[OFS_W-1:0]};
   assign rom_cs = access & ~ram_mode;
   assign ram_cs = access &  ram_mode;
   assign we     = access &  ram_mode & wr;
endmodule

// File: rtl/bank_window_map.sv
`timescale 1ns/1ps
module bank_window_map
   import bwm_pkg::*;
#(
   parameter int             CPU_AW     = 16,
   parameter int             DW         = 8,
   parameter int             IO_AW      = 8,
   parameter int             IO_DEC_W   = 5,
   parameter int             ALIAS_W    = 2,
   parameter int             RAM_PORT   = 24,
   parameter int             ROM_PORT   = 28,
   parameter int             ROM_BANK_W = 5,
   parameter int             RAM_BANK_W = 4,
   parameter int             SEL_BIT    = 7,
   parameter logic [DW-1:0]  READBACK   = 8'hFF,
   localparam int            OFS_W      = CPU_AW - 1,
   localparam int            PA_W       = OFS_W + max2(ROM_BANK_W, RAM_BANK_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] mem_addr,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic [IO_AW-1:0]  io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DW-1:0]     io_wdata,
   output logic [DW-1:0]     io_rdata,
   output logic              io_hit,
   output logic [PA_W-1:0]   phys_addr,
   output logic              rom_cs,
   output logic              ram_cs,
   output logic              mem_we
);
   latch_tgt_e            tgt;
   logic [ROM_BANK_W-1:0] rom_page;
   logic [RAM_BANK_W-1:0] ram_page;
   logic                  ram_mode;
   logic                  ram_sel_unused;

   bwm_io_decode #(
      .IO_AW(IO_AW), .DEC_W(IO_DEC_W), .ALIAS_W(ALIAS_W),
      .RAM_PORT(RAM_PORT), .ROM_PORT(ROM_PORT)
   ) u_dec (
      .io_addr(io_addr),
      .tgt    (tgt)
   );

   bwm_page_latch #(
      .DW(DW), .KEEP_W(RAM_BANK_W), .HAS_SEL(1'b0), .SEL_BIT(SEL_BIT)
   ) u_ram_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .load (io_wr && tgt == TGT_RAM),
      .wdata(io_wdata),
      .page (ram_page),
      .sel  (ram_sel_unused)
   );

   bwm_page_latch #(
      .DW(DW), .KEEP_W(ROM_BANK_W), .HAS_SEL(1'b1), .SEL_BIT(SEL_BIT)
   ) u_rom_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .load (io_wr && tgt == TGT_ROM),
      .wdata(io_wdata),
      .page (rom_page),
      .sel  (ram_mode)
   );

   bwm_translate #(
      .CPU_AW(CPU_AW), .OFS_W(OFS_W), .ROM_W(ROM_BANK_W),
      .RAM_W(RAM_BANK_W), .PA_W(PA_W)
   ) u_xlat (
      .cpu_addr(mem_addr),
      .rd      (mem_rd),
      .wr      (mem_wr),
      .rom_page(rom_page),
      .ram_page(ram_page),
      .ram_mode(ram_mode),
      .phys    (phys_addr),
      .rom_cs  (rom_cs),
      .ram_cs  (ram_cs),
      .we      (mem_we)
   );

   assign io_hit   = io_rd && (tgt != TGT_NONE);
   assign io_rdata = io_hit ? READBACK : '0;
endmodule

// File: rtl/bwm_checker.sv
`timescale 1ns/1ps
module bwm_checker #(
   parameter int            CPU_AW     = 16,
   parameter int            DW         = 8,
   parameter int            IO_AW      = 8,
   parameter int            RAM_BANK_W = 4,
   parameter int            PA_W       = 20,
   parameter logic [DW-1:0] READBACK   = 8'hFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CPU_AW-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [IO_AW-1:0]  io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DW-1:0]     io_wdata,
   input logic [DW-1:0]     io_rdata,
   input logic              io_hit,
   input logic [PA_W-1:0]   phys_addr,
   input logic              rom_cs,
   input logic              ram_cs,
   input logic              mem_we
);
   localparam int OFS_W = CPU_AW - 1;

   a_r2_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[OFS_W-1:0] == mem_addr[OFS_W-1:0]);

   a_r4_ram_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs |-> ((phys_addr >> (OFS_W + RAM_BANK_W)) == '0));

   a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_cs, ram_cs}));

   a_r6_we_needs_ram: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (ram_cs && mem_wr));

   a_r7_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mem_addr[CPU_AW-1] |-> !(rom_cs || ram_cs || mem_we));

   a_r9_fixed_readback: assert property (@(posedge clk) disable iff (!rst_n)
      io_hit |-> (io_rdata == READBACK));

   a_r10_map_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> (!$stable(mem_addr) || $stable(phys_addr)));

   logic [IO_AW-1:0] unused_io;
   logic [DW-1:0]    unused_wd;
   logic             unused_rd;
   assign unused_io = io_addr;
   assign unused_wd = io_wdata;
   assign unused_rd = mem_rd ^ io_rd;
endmodule

bind bank_window_map bwm_checker #(
   .CPU_AW(CPU_AW), .DW(DW), .IO_AW(IO_AW), .RAM_BANK_W(RAM_BANK_W),
   .PA_W(PA_W), .READBACK(READBACK)
) u_chk (.*);

// File: tb/sim_bank_window_map.sv
`timescale 1ns/1ps
module sim_bank_window_map;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr = '0;
   logic        mem_rd = 1'b0;
   logic        mem_wr = 1'b0;
   logic [7:0]  io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_hit;
   logic [19:0] phys_addr;
   logic        rom_cs, ram_cs, mem_we;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_ram = '0;
   logic [7:0] m_rom = '0;

   always #2.5 clk = ~clk;

   bank_window_map u0 (.*);

   function automatic logic [22:0] expect_map(input logic [7:0] rl, input logic [7:0] ol,
                                               input logic [15:0] a, input logic rd,
                                               input logic wr);
      logic acc, s;
      logic [19:0] p;
      acc = !a[15] && (rd || wr);
      s   = ol[7];
      p   = s ? {1'b0, rl[3:0], a[14:0]} : {ol[4:0], a[14:0]};
      return {p, acc && !s, acc && s, acc && s && wr};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic probe(input string req, input logic [15:0] a, input logic rd, input logic wr);
      @(negedge clk);
      mem_addr = a; mem_rd = rd; mem_wr = wr;
      #1;
      chk(req, {9'd0, phys_addr, rom_cs, ram_cs, mem_we},
          {9'd0, expect_map(m_ram, m_rom, a, rd, wr)});
      mem_rd = 1'b0; mem_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state visible before release, then after release
      mem_addr = 16'h1234; mem_rd = 1'b1; #1;
      chk("R1 in reset", {9'd0, phys_addr, rom_cs, ram_cs, mem_we}, {9'd0, 20'h01234, 3'b100});
      mem_rd = 1'b0;
      rst_n = 1'b1;
      probe("R1 after reset", 16'h1234, 1'b1, 1'b0);
      probe("R1 after reset top", 16'h7FFF, 1'b1, 1'b0);

      // R3 R5 R8: sweep every ROM register value via rotating aliases
      m_ram = 8'hFA;
      io_write(8'h18, m_ram);
      for (int v = 0; v < 256; v++) begin
         logic [7:0] pa;
         pa = {v[7:5] ^ 3'b101, 3'b111, v[1:0]};
         m_rom = v[7:0];
         io_write(pa, m_rom);
         probe("R3/R5 read sweep", 16'((v * 131) & 16'h7FFF), 1'b1, 1'b0);
         probe("R6 write sweep", 16'((v * 977 + 5) & 16'h7FFF), 1'b0, 1'b1);
      end

      // R4 R8: sweep every RAM register value with RAM selected
      m_rom = 8'hE0;
      io_write(8'h3D, m_rom);
      for (int v = 0; v < 256; v++) begin
         logic [7:0] pa;
         pa = {v[4:2], 3'b110, v[1:0]};
         m_ram = v[7:0];
         io_write(pa, m_ram);
         probe("R4 read sweep", 16'((v * 251 + 7) & 16'h7FFF), 1'b1, 1'b0);
         probe("R6 ram write", 16'((v * 61) & 16'h7FFF), 1'b0, 1'b1);
      end

      // R7: upper half and idle strobes
      probe("R7 upper read", 16'h8000, 1'b1, 1'b0);
      probe("R7 upper write", 16'hFFFF, 1'b0, 1'b1);
      probe("R7 idle", 16'h0100, 1'b0, 1'b0);

      // R8: writes to non-register ports change nothing
      m_ram = 8'h05; io_write(8'h19, m_ram);
      m_rom = 8'h13; io_write(8'h1E, m_rom);
      io_write(8'h00, 8'h9F);
      io_write(8'h08, 8'h9F);
      io_write(8'h17, 8'h9F);
      io_write(8'hE0, 8'h9F);
      probe("R8 other ports ignored", 16'h4321, 1'b1, 1'b0);

      // R9: read-back of register ports and of other ports
      for (int p = 0; p < 32; p++) begin
         @(negedge clk);
         io_addr = {p[2:0] ^ 3'b011, p[4:0]}; io_rd = 1'b1;
         #1;
         if (p >= 24) chk("R9 latch port read", {23'd0, io_hit, io_rdata}, {23'd0, 1'b1, 8'hFF});
         else         chk("R9 other port read", {23'd0, io_hit, io_rdata}, {23'd0, 1'b0, 8'h00});
      end
      @(negedge clk); io_rd = 1'b0;
      probe("R9 read no side effect", 16'h0042, 1'b1, 1'b0);

      // R10: access during the write cycle uses old mapping
      @(negedge clk);
      io_addr = 8'h1C; io_wdata = 8'h0B; io_wr = 1'b1;
      mem_addr = 16'h0200; mem_rd = 1'b1;
      #1;
      chk("R10 old mapping", {12'd0, phys_addr}, {12'd0, 5'h13, 15'h0200});
      @(negedge clk);
      io_wr = 1'b0; m_rom = 8'h0B;
      #1;
      chk("R10 new mapping", {12'd0, phys_addr}, {12'd0, 5'h0B, 15'h0200});
      mem_rd = 1'b0;

      // R5: RAM register bit 7 does not select
      m_ram = 8'h8C; io_write(8'h1A, m_ram);
      probe("R5 ram bit7 no select", 16'h0777, 1'b0, 1'b1);

      // R1: reset in mid-run returns to page 0 of ROM
      m_rom = 8'h85; io_write(8'h1F, m_rom);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      m_rom = 8'h00; m_ram = 8'h00;
      probe("R1 reset again", 16'h5A5A, 1'b1, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule